// File: doc/BRIEF.md
# Prescaled Reload Down-Counter Timer

This block is one timer channel that software drives through four word-addressed registers. The channel holds a run bit, a control word, a reload value and a live down-counter. While the run bit is set, a prescaler divides the module clock by a power of four chosen in the control word. The prescaler produces one count enable per period, and each enable lowers the counter by one.

A count enable that finds the counter at zero is an underflow. The counter takes the reload value and keeps running, so the channel fires periodically. Each underflow sets a sticky flag in the control word. The interrupt line is high while both that flag and the interrupt enable bit are set. Software clears the flag by writing the control word back with the flag bit at zero. The other control bits take the values written in the same access.

The usual setup sequence is: stop the channel, write the period into both the reload and the counter registers, then start it.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset the counter and reload registers read 0xFFFFFFFF, the control and run registers read 0, and `irq` is 0.
- R2: Word address 0 is the run register (bit 0, other bits read 0). Address 1 is the control word (16 bits, zero-extended). Address 2 is the reload value. Address 3 returns the live counter. Reads are combinational from `bus_addr`.
- R3: While running with control bits [2:0] = s in 0..3, the counter drops by one every 4<<(2*s) clock cycles (4, 16, 64, 256). The first drop comes that many cycles after the clock edge that writes the run bit to 1.
- R4: Control select values 4 to 7 divide by 4.
- R5: A count enable with the counter at 0 loads the reload value. Counting continues, so the period is (reload+1) enables.
- R6: Control bit 8 is set by every underflow and stays set while software does not clear it.
- R7: A control write with bit 8 = 0 clears the flag. A control write with bit 8 = 1 leaves the flag as it was. All other control bits take the written value.
- R8: If an underflow and a control write with bit 8 = 0 fall in the same cycle, the flag ends up set.
- R9: Writing 0 to run bit 0 halts counting with the count held. The prescaler restarts from zero, so the next start again waits a full prescale period.
- R10: The counter accepts direct writes at address 3, stopped or running. In a cycle with both a write and a count enable, the written value is stored.
- R11: `irq` equals the flag (control bit 8) AND the interrupt enable (control bit 5). A control value of 0x0020 enables the interrupt with the /4 ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe for the current cycle |
| bus_addr | input | 2 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Underflow interrupt request (level) |

## Verification
Two events can land on the same clock edge. One is a hardware underflow that sets the flag; the other is a software write of the control word that clears it. The bench keeps a cycle model of the prescaler and the counter. From that model it predicts the edge on which the next underflow will occur, and it issues the clearing write on exactly that edge. It then reads the control word back and expects bit 8 still set and `irq` high. The same prediction is used to place a counter write on a count-enable edge, and the bench checks that the written value, not its decrement, is stored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      REG_RUN    = 2'd0,
      REG_CTRL   = 2'd1,
      REG_RELOAD = 2'd2,
      REG_COUNT  = 2'd3
   } tmr_reg_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int SEL_W      = 3,
   parameter int NUM_RATIOS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int PRE_W = 2 * NUM_RATIOS;
   localparam int IDX_W = (NUM_RATIOS > 1) ? $clog2(NUM_RATIOS) : 1;

   if (NUM_RATIOS < 2 || NUM_RATIOS > (1 << SEL_W)) begin : g_bad_ratios
      $error("tmr_prescaler: NUM_RATIOS must lie in 2 .. 2**SEL_W");
   end

   logic [PRE_W-1:0] lim_tbl [NUM_RATIOS];
   logic [PRE_W-1:0] lim;
   logic [PRE_W-1:0] pre_q;
   logic             sel_ok;

   for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_lim
      assign lim_tbl[i] = {PRE_W{1'b1}} >> (PRE_W - 2 * (i + 1));
   end

   assign sel_ok = ({1'b0, sel_i} < (SEL_W + 1)'(NUM_RATIOS));
   assign lim    = sel_ok ? lim_tbl[sel_i[IDX_W-1:0]] : lim_tbl[0];
   assign tick_o = run_i && (pre_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_q <= '0;
      else if (!run_i) pre_q <= '0;
      else if (tick_o) pre_q <= '0;
      else             pre_q <= pre_q + 1'b1;
   end

   // R9
   stop_clears_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !tick_o);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] count_o,
   output logic             uf_o
);
   if (CNT_W < 2) begin : g_bad_width
      $error("tmr_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);
   assign uf_o    = tick_i && !load_i && at_zero;
   assign count_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '1;
      else if (load_i)  cnt_q <= load_val_i;
      else if (tick_i)  cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
   end

   // R5
   reload_on_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf_o |=> count_o == $past(reload_i));
   // R9
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_i) |=> $stable(count_o));
   // R10
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> count_o == $past(load_val_i));

endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg #(
   parameter int CTRL_W   = 16,
   parameter int FLAG_BIT = 8,
   parameter int IE_BIT   = 5,
   parameter int SEL_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [CTRL_W-1:0] wdata_i,
   input  logic              uf_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [SEL_W-1:0]  sel_o,
   output logic              irq_o
);
   localparam logic [CTRL_W-1:0] FLAG_MASK = CTRL_W'(1) << FLAG_BIT;

   if (FLAG_BIT >= CTRL_W || IE_BIT >= CTRL_W || SEL_W > CTRL_W
       || FLAG_BIT < SEL_W || IE_BIT < SEL_W || IE_BIT == FLAG_BIT) begin : g_bad_fields
      $error("tmr_ctrl_reg: control fields overlap or exceed CTRL_W");
   end

   logic [CTRL_W-1:0] bits_q;
   logic              flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_i) bits_q <= wdata_i & ~FLAG_MASK;
         if (uf_i)      flag_q <= 1'b1;
         else if (wr_i) flag_q <= flag_q & wdata_i[FLAG_BIT];
      end
   end

   assign ctrl_o = bits_q | (flag_q ? FLAG_MASK : '0);
   assign sel_o  = bits_q[SEL_W-1:0];
   assign irq_o  = flag_q & bits_q[IE_BIT];

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf_i |=> ctrl_o[FLAG_BIT]);
   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o[FLAG_BIT] && !uf_i && !wr_i) |=> ctrl_o[FLAG_BIT]);
   // R7
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !uf_i && !wdata_i[FLAG_BIT]) |=> !ctrl_o[FLAG_BIT]);

endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer #(
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 32,
   parameter int CTRL_W     = 16,
   parameter int SEL_W      = 3,
   parameter int NUM_RATIOS = 4,
   parameter int FLAG_BIT   = 8,
   parameter int IE_BIT     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   import tmr_pkg::*;

   if (CNT_W > DATA_W || CTRL_W > DATA_W) begin : g_bad_widths
      $error("prescaled_reload_timer: register wider than data bus");
   end

   logic             run_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] count;
   logic [CTRL_W-1:0] ctrl;
   logic [SEL_W-1:0] sel;
   logic             tick;
   logic             uf;
   logic             wr_run, wr_ctrl, wr_reload, wr_count;

   assign wr_run    = bus_we && (tmr_reg_e'(bus_addr) == REG_RUN);
   assign wr_ctrl   = bus_we && (tmr_reg_e'(bus_addr) == REG_CTRL);
   assign wr_reload = bus_we && (tmr_reg_e'(bus_addr) == REG_RELOAD);
   assign wr_count  = bus_we && (tmr_reg_e'(bus_addr) == REG_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         reload_q <= '1;
      end else begin
         if (wr_run)    run_q    <= bus_wdata[0];
         if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
      end
   end

   tmr_prescaler #(.SEL_W(SEL_W), .NUM_RATIOS(NUM_RATIOS)) u_pre (
      .clk(clk), .rst_n(rst_n), .run_i(run_q), .sel_i(sel), .tick_o(tick));

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(wr_count),
      .load_val_i(bus_wdata[CNT_W-1:0]), .reload_i(reload_q),
      .count_o(count), .uf_o(uf));

   tmr_ctrl_reg #(.CTRL_W(CTRL_W), .FLAG_BIT(FLAG_BIT), .IE_BIT(IE_BIT),
                  .SEL_W(SEL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl),
      .wdata_i(bus_wdata[CTRL_W-1:0]), .uf_i(uf),
      .ctrl_o(ctrl), .sel_o(sel), .irq_o(irq));

   always_comb begin
      unique case (tmr_reg_e'(bus_addr))
         REG_RUN:    bus_rdata = DATA_W'(run_q);
         REG_CTRL:   bus_rdata = DATA_W'(ctrl);
         REG_RELOAD: bus_rdata = DATA_W'(reload_q);
         default:    bus_rdata = DATA_W'(count);
      endcase
   end

   // R9
   halted_no_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !$past(run_q)) |-> !uf);

endmodule

// File: tb/sim_prescaled_reload_timer.sv
`timescale 1ns/1ps
module sim_prescaled_reload_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = 2'd3;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   prescaled_reload_timer u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   // reference model built from the requirements
   logic        m_run;
   logic [7:0]  m_pre;
   logic [31:0] m_cnt, m_rld;
   logic [15:0] m_ctrl;
   logic        m_flag;

   function automatic int f_lim(input logic [2:0] s);
      return (s < 3'd4) ? ((4 << (2 * s)) - 1) : 3;
   endfunction
   function automatic int f_ratio(input logic [2:0] s);
      return f_lim(s) + 1;
   endfunction
   function automatic logic f_tick();
      return m_run && (int'(m_pre) >= f_lim(m_ctrl[2:0]));
   endfunction

   always @(posedge clk or negedge rst_n) begin : mdl
      logic tk, uf, wcnt, wctl;
      if (!rst_n) begin
         m_run <= 0; m_pre <= 0; m_cnt <= '1; m_rld <= '1; m_ctrl <= 0; m_flag <= 0;
      end else begin
         tk   = f_tick();
         wcnt = bus_we && bus_addr == 2'd3;
         wctl = bus_we && bus_addr == 2'd1;
         uf   = tk && !wcnt && m_cnt == 0;
         m_pre <= (!m_run || tk) ? 8'd0 : m_pre + 8'd1;
         if (wcnt)    m_cnt <= bus_wdata;
         else if (tk) m_cnt <= (m_cnt == 0) ? m_rld : m_cnt - 1;
         if (bus_we && bus_addr == 2'd2) m_rld <= bus_wdata;
         if (bus_we && bus_addr == 2'd0) m_run <= bus_wdata[0];
         if (wctl) m_ctrl <= bus_wdata[15:0] & ~16'h0100;
         m_flag <= uf ? 1'b1 : (wctl ? (m_flag & bus_wdata[8]) : m_flag);
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_now(input logic [1:0] a, input logic [31:0] d);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 0; bus_addr = 2'd3;
   endtask
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_now(a, d);
   endtask
   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_we = 0; bus_addr = a; #1;
      v = bus_rdata;
   endtask
   task automatic idle_check();
      @(negedge clk);
      bus_we = 0; bus_addr = 2'd3; #1;
      chk(bus_rdata == m_cnt, "R5/R3 counter vs model", bus_rdata, m_cnt);
      chk(irq == (m_flag & m_ctrl[5]), "R11 irq vs model", 32'(irq), 32'(m_flag & m_ctrl[5]));
   endtask
   // program and measure clock edges from start until irq
   task automatic period_test(input logic [15:0] c, input logic [31:0] v, input string req);
      int n;
      logic [31:0] r;
      wr(0, 0); wr(1, 0); wr(1, 32'(c)); wr(2, v); wr(3, v);
      rd(2, r); chk(r == v, "R2 reload readback", r, v);
      rd(3, r); chk(r == v, "R10 counter write while stopped", r, v);
      wr(0, 1);
      n = 0;
      while (!irq && n < 5000) begin @(posedge clk); #1; n++; end
      chk(n == f_ratio(c[2:0]) * (v + 1), req, n, f_ratio(c[2:0]) * (v + 1));
      rd(3, r); chk(r == v, "R5 reload after underflow", r, v);
      rd(1, r); chk(r == (32'(c) | 32'h100), "R6 flag set on underflow", r, 32'(c) | 32'h100);
   endtask

   initial begin
      #(4.0 * 200000);
      errors++; checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] r, v1;
      void'($urandom(32'h5eed_2024));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 / R2 reset state
      rd(0, r); chk(r == 0, "R1 run reg reset", r, 0);
      rd(1, r); chk(r == 0, "R1 ctrl reset", r, 0);
      rd(2, r); chk(r == 32'hFFFF_FFFF, "R1 reload reset", r, 32'hFFFF_FFFF);
      rd(3, r); chk(r == 32'hFFFF_FFFF, "R1 counter reset", r, 32'hFFFF_FFFF);
      chk(irq == 0, "R1 irq reset", 32'(irq), 0);

      period_test(16'h0020, 5, "R3 R11 /4 period");
      repeat (8) @(negedge clk);
      rd(1, r); chk(r[8] == 1, "R6 flag sticky", r, 32'h120);
      wr(0, 0);
      wr(1, 32'h0020); rd(1, r); chk(r == 32'h20, "R7 clear by writing 0", r, 32'h20);
      chk(irq == 0, "R11 irq low after clear", 32'(irq), 0);
      wr(1, 32'h0125); rd(1, r); chk(r == 32'h25, "R7 writing 1 keeps flag clear", r, 32'h25);

      period_test(16'h0026, 2, "R4 reserved select divides by 4");
      period_test(16'h0021, 3, "R3 /16 period");
      period_test(16'h0023, 1, "R3 /256 period");

      // R9 halt holds count, restart waits a full prescale period
      wr(0, 0); rd(3, v1);
      repeat (40) @(negedge clk);
      rd(3, r); chk(r == v1, "R9 count held while stopped", r, v1);
      wr(1, 32'h20); wr(3, 10); wr(0, 1);
      repeat (3) @(posedge clk); #1;
      chk(bus_rdata == 10, "R9 no early decrement after restart", bus_rdata, 10);
      @(posedge clk); #1;
      chk(bus_rdata == 9, "R9 R3 first decrement after 4 cycles", bus_rdata, 9);

      // R8 collision: clear write on the underflow edge
      wr(0, 0); wr(2, 3); wr(3, 3); wr(1, 32'h20); wr(0, 1);
      forever begin @(negedge clk); if (f_tick() && m_cnt == 0) break; end
      wr_now(1, 32'h20);
      rd(1, r); chk(r == 32'h120, "R8 hardware set wins", r, 32'h120);
      chk(irq == 1, "R8 R11 irq high after collision", 32'(irq), 1);

      // R10 write on a count-enable edge
      forever begin @(negedge clk); if (f_tick() && m_cnt != 0) break; end
      wr_now(3, 7);
      rd(3, r); chk(r == 7, "R10 write wins over tick", r, 7);

      // constrained random phase
      for (int i = 0; i < 4000; i++) begin
         int k;
         k = $urandom % 10;
         if (k < 7) idle_check();
         else begin
            logic [1:0] a;
            logic [31:0] d;
            a = 2'($urandom % 4);
            case (a)
               2'd0: d = 32'($urandom % 5 != 0);
               2'd1: d = ((($urandom % 2) << 8) | (($urandom % 4 != 0) << 5)
                         | (($urandom % 3 == 0) ? $urandom % 8 : $urandom % 2));
               default: d = $urandom % 24;
            endcase
            wr(a, d);
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule